// File: doc/BRIEF.md
# Sleep State Transition Controller

This block keeps track of the system sleep level of a processor package. It does nothing by itself. A level changes only when the external chipset side presents a power-management request, or when reset is applied. Each request carries a 2-bit target code. The block checks the target against a fixed table of permitted moves. An accepted request that enters a sleep level is answered with a completion strobe that carries the code of the level reached. A refused request raises a one-cycle machine-check error pulse and leaves everything else as it was.

The table is asymmetric. From the running level (S0) the only permitted move is into the light sleep level (S1). From S1 a request may go back to S0, or down to the suspend-to-memory level (S3) or the off level (S4/S5). S3 and S4/S5 have no request-driven exit: only reset brings the block back to S0. While the block is in S1 it raises a core low-power enable. While it is in S3 it raises a memory self-refresh enable.

Top module: `slp_state_ctrl`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it is released, cur_state is 00 (S0), and cmp_valid, mce_pulse, core_lowpwr_en and mem_selfrefresh_en are all 0. State codes are 00 = S0, 01 = S1, 10 = S3 and 11 = S4/S5.
- R2: A request for 01 while in 00 is accepted. After the next rising edge, cur_state is 01 and cmp_valid is high for one cycle with cmp_state = 01.
- R3: A request while in 00 whose target is 00, 10 or 11 is illegal. After the next edge, mce_pulse is high for one cycle, cur_state stays 00 and cmp_valid stays 0.
- R4: A request for 00 while in 01 is accepted. After the next edge, cur_state is 00 and no completion strobe is sent.
- R5: A request for 10 or 11 while in 01 is accepted. After the next edge, cur_state equals the target and cmp_valid is high for one cycle with cmp_state equal to the target.
- R6: Any request while in 10 or 11 is illegal, and so is a request for 01 while in 01. Each one gives a one-cycle mce_pulse, cur_state unchanged and no completion.
- R7: Asserting reset from any state returns cur_state to 00 at once.
- R8: core_lowpwr_en is 1 exactly when cur_state is 01. mem_selfrefresh_en is 1 exactly when cur_state is 10.
- R9: In a cycle with req_valid low, cur_state does not change, and neither cmp_valid nor mce_pulse rises in the next cycle.
- R10: cmp_valid and mce_pulse are never high in the same cycle. Each one follows a single request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; forces S0 |
| req_valid | input | 1 | Power-management request strobe |
| req_state | input | 2 | Target level code of the request |
| cur_state | output | 2 | Current level code |
| cmp_valid | output | 1 | Completion message strobe |
| cmp_state | output | 2 | Level code carried by the completion |
| mem_selfrefresh_en | output | 1 | Memory self-refresh enable (S3) |
| core_lowpwr_en | output | 1 | Core halt-like low-power enable (S1) |
| mce_pulse | output | 1 | One-cycle machine-check error on an illegal request |

## Verification
The block has no tunable parameters; its only width is the 2-bit state code fixed in the package, so the bench builds it as delivered. Because every level is reachable within two requests of reset, the bench walks all sixteen pairs of current level and requested target. It also covers idle cycles between requests, back-to-back requests, and a reset from each of S1, S3 and S4/S5. This exposes both the legal moves and the reset-only exits of the two deep levels.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SLP_RUN     = 2'b00,
    SLP_HALT    = 2'b01,
    SLP_SUSPEND = 2'b10,
    SLP_OFF     = 2'b11
  } slp_state_e;

  // Permitted-move table: returns 1 when tgt may follow cur.
  function automatic logic slp_move_ok(slp_state_e cur, slp_state_e tgt);
    logic ok;
    case (cur)
      SLP_RUN:  ok = (tgt == SLP_HALT);
      SLP_HALT: ok = (tgt != SLP_HALT);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Entering any level other than running is announced.
  function automatic logic slp_announces(slp_state_e tgt);
    return tgt != SLP_RUN;
  endfunction
endpackage

// File: rtl/slp_judge.sv
module slp_judge
  import slp_pkg::*;
(
  input  logic       req_valid,
  input  slp_state_e cur,
  input  slp_state_e tgt,
  output logic       accept,
  output logic       reject
);
  logic ok;
  always_comb begin
    ok     = slp_move_ok(cur, tgt);
    accept = req_valid && ok;
    reject = req_valid && !ok;
  end
endmodule

// File: rtl/slp_state_reg.sv
module slp_state_reg
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  slp_state_e tgt,
  output slp_state_e cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= SLP_RUN;
    else if (accept) cur <= tgt;
  end
endmodule

// File: rtl/slp_notify.sv
module slp_notify
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       reject,
  input  slp_state_e tgt,
  output logic       cmp_valid,
  output slp_state_e cmp_state,
  output logic       mce_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      cmp_state <= SLP_RUN;
      mce_pulse <= 1'b0;
    end else begin
      cmp_valid <= accept && slp_announces(tgt);
      mce_pulse <= reject;
      if (accept) cmp_state <= tgt;
    end
  end
endmodule

// File: rtl/slp_state_ctrl.sv
module slp_state_ctrl
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_state,
  output logic [CODE_W-1:0] cur_state,
  output logic              cmp_valid,
  output logic [CODE_W-1:0] cmp_state,
  output logic              mem_selfrefresh_en,
  output logic              core_lowpwr_en,
  output logic              mce_pulse
);
  slp_state_e tgt;
  slp_state_e cur;
  slp_state_e cmp_code;
  logic       accept_ev;
  logic       reject_ev;

  assign tgt = slp_state_e'(req_state);

  slp_judge u_judge (
    .req_valid (req_valid),
    .cur       (cur),
    .tgt       (tgt),
    .accept    (accept_ev),
    .reject    (reject_ev)
  );

  slp_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept_ev),
    .tgt    (tgt),
    .cur    (cur)
  );

  slp_notify u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_ev),
    .reject    (reject_ev),
    .tgt       (tgt),
    .cmp_valid (cmp_valid),
    .cmp_state (cmp_code),
    .mce_pulse (mce_pulse)
  );

  assign cur_state          = cur;
  assign cmp_state          = cmp_code;
  assign core_lowpwr_en     = (cur == SLP_HALT);
  assign mem_selfrefresh_en = (cur == SLP_SUSPEND);
endmodule

// File: rtl/slp_state_ctrl_chk.sv
module slp_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] cur_state,
  input logic       cmp_valid,
  input logic [1:0] cmp_state,
  input logic       mce_pulse,
  input logic       accept_ev,
  input logic       reject_ev
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> cur_state == $past(cur_state)); // R9
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n) mce_pulse |-> cur_state == $past(cur_state)); // R3
  AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cur_state[1] |=> cur_state == $past(cur_state)); // R6
  AST_RUN_ONLY_HALT: assert property (@(posedge clk) disable iff (!rst_n) cur_state == 2'b00 |=> (cur_state == 2'b00 || cur_state == 2'b01)); // R3
  AST_CMP_TAG: assert property (@(posedge clk) disable iff (!rst_n) cmp_valid |-> cmp_state == cur_state && cur_state != 2'b00); // R5
  AST_CMP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) cmp_valid |-> cur_state != $past(cur_state)); // R2
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(cmp_valid && mce_pulse)); // R10
  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(accept_ev && reject_ev)); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mce_pulse |-> $past(req_valid)); // R10
endmodule

bind slp_state_ctrl slp_state_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .cur_state (cur_state),
  .cmp_valid (cmp_valid),
  .cmp_state (cmp_state),
  .mce_pulse (mce_pulse),
  .accept_ev (accept_ev),
  .reject_ev (reject_ev)
);

// File: tb/slp_state_ctrl_tb.sv
module slp_state_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic [1:0] req_state = 0;
  logic [1:0] cur_state, cmp_state;
  logic       cmp_valid, mem_selfrefresh_en, core_lowpwr_en, mce_pulse;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] model = 2'b00;

  typedef struct {
    logic [1:0] st;
    logic       cmp;
    logic [1:0] cst;
    logic       err;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slp_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .cur_state(cur_state), .cmp_valid(cmp_valid), .cmp_state(cmp_state),
    .mem_selfrefresh_en(mem_selfrefresh_en), .core_lowpwr_en(core_lowpwr_en),
    .mce_pulse(mce_pulse)
  );

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(exp_t e);
    check(e.tag, "cur_state", {2'b0, cur_state}, {2'b0, e.st});
    check(e.tag, "cmp_valid", {3'b0, cmp_valid}, {3'b0, e.cmp});
    if (e.cmp) check(e.tag, "cmp_state", {2'b0, cmp_state}, {2'b0, e.cst});
    check(e.tag, "mce_pulse", {3'b0, mce_pulse}, {3'b0, e.err});
    check("R8", "core_lowpwr_en", {3'b0, core_lowpwr_en}, {3'b0, e.st == 2'b01});
    check("R8", "mem_selfrefresh_en", {3'b0, mem_selfrefresh_en}, {3'b0, e.st == 2'b10});
  endtask

  // Monitor: one expected item per driven cycle, compared mid-cycle.
  always @(negedge clk) begin
    if (q.size() > 0) check_all(q.pop_front());
  end

  // Driver: apply one cycle of stimulus and push what the rules predict.
  task automatic drive(logic v, logic [1:0] t, string tag);
    exp_t e;
    logic legal;
    @(negedge clk);
    req_valid = v;
    req_state = t;
    legal = (model == 2'b00) ? (t == 2'b01) :
            (model == 2'b01) ? (t != 2'b01) : 1'b0;
    e.tag = tag;
    e.err = v && !legal;
    e.cmp = v && legal && (t != 2'b00);
    e.cst = t;
    if (v && legal) model = t;
    e.st = model;
    @(posedge clk);
    #1;
    q.push_back(e);
    req_valid = 0;
  endtask

  task automatic do_reset(string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 0;
    model = 2'b00;
    #1;
    e.st = 2'b00; e.cmp = 0; e.cst = 0; e.err = 0; e.tag = tag;
    check_all(e);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  task automatic go_to(logic [1:0] s);
    do_reset("R7");
    if (s != 2'b00) drive(1, 2'b01, "R2");
    if (s[1]) drive(1, s, "R5");
  endtask

  initial begin
    do_reset("R1");
    drive(0, 2'b01, "R9");
    drive(1, 2'b00, "R3");
    drive(1, 2'b10, "R3");
    drive(1, 2'b11, "R3");
    drive(1, 2'b01, "R2");
    drive(0, 2'b10, "R9");
    drive(1, 2'b01, "R6");
    drive(1, 2'b00, "R4");
    drive(1, 2'b01, "R2");
    drive(1, 2'b10, "R5");
    for (int t = 0; t < 4; t++) drive(1, 2'(t), "R6");
    drive(0, 2'b00, "R9");
    do_reset("R7");
    drive(1, 2'b01, "R2");
    drive(1, 2'b11, "R5");
    for (int t = 0; t < 4; t++) drive(1, 2'(t), "R6");
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        go_to(2'(s));
        drive(1, 2'(t), "R10");
        drive(0, 2'b00, "R10");
      end
    end
    go_to(2'b01);
    do_reset("R7");
    drive(0, 2'b00, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule